// File: doc/BRIEF.md
# DMA Request Source Router

This block sits in front of a DMA channel arbiter and decides which peripheral request line wakes each channel. Every channel owns one 32-bit configuration word. The word holds a source number, a channel enable, a forced-request flag and a trigger-gating flag. The router drives one request output per channel from the selected peripheral line. The arbiter and transfer engine downstream see only these outputs.

A peripheral line can belong to at most one channel at a time. A write that would give a second channel a source that is already taken is discarded as a whole. Software finds out by reading the word back and seeing that it differs from what it wrote. The lowest channels can also be paced by external periodic trigger pulses. On those channels one request passes per pulse instead of following the line level.

Top module: `dma_req_router`

## Requirements
- R1: After reset every configuration word reads as zero and every channel request output is low.
- R2: A configuration word stores enable at bit 31, trigger gating at bit 30, forced request at bit 29 and the source number in bits [7:0]. Bits [28:8] always read as zero.
- R3: A channel whose enable bit is clear never drives its request output high, whatever its other fields and inputs are.
- R4: An enabled channel with a nonzero source, no forced request and no trigger gating drives its request output equal to the level of peripheral line number `source`, in the same cycle.
- R5: Source number 0 selects no line. An enabled channel with source 0 and no forced request keeps its output low even when every peripheral line is high.
- R6: An enabled channel with the forced-request bit set holds its output high regardless of its source and the peripheral lines.
- R7: A write that carries a nonzero source number already held by a different channel is discarded completely. The target word keeps its previous value, so its readback differs from the written value.
- R8: Rewriting a channel with the source it already holds is accepted. Once a channel changes to another source, the old source can be claimed by a different channel.
- R9: On channels 0 to NTRIG-1 with trigger gating set, the output is high only in the cycle in which that channel's trigger input rises while the selected line is high. A trigger input that stays high gives no further request.
- R10: On channels NTRIG and above, the trigger-gating bit is not stored. It reads back as zero and the channel follows its source level as in R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration word at cfg_addr |
| cfg_addr | input | $clog2(NCH) | Channel index for write and read |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Configuration word of channel cfg_addr (combinational) |
| periph_req | input | NSRC | Peripheral request levels; bit k is source k, bit 0 unused |
| trig_in | input | NTRIG | Periodic trigger pulses for the lowest channels |
| ch_req | output | NCH | Request output per channel |

## Verification
The checker assumes that cfg_addr always names an existing channel, that trigger inputs are synchronous to clk, and that reset starts the run, so the exclusive-source property holds from the first cycle. The bench drives addresses only below NCH and changes all inputs on the falling edge. Trigger pulses are raised and held across a full clock edge, so that both the rising cycle and the held cycle can be observed on the outputs.

// File: rtl/dma_req_router.sv
module dma_req_router #(
  parameter int NCH   = 32,
  parameter int NSRC  = 256,
  parameter int NTRIG = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [$clog2(NCH)-1:0] cfg_addr,
  input  logic [31:0]            cfg_wdata,
  output logic [31:0]            cfg_rdata,
  input  logic [NSRC-1:0]        periph_req,
  input  logic [NTRIG-1:0]       trig_in,
  output logic [NCH-1:0]         ch_req
);
  localparam int AW   = $clog2(NCH);
  localparam int SW   = $clog2(NSRC);
  localparam int PADW = 29 - SW;

  logic [NCH-1:0]   en_r, tm_r, ao_r;
  logic [SW-1:0]    src_r [NCH];
  logic [NTRIG-1:0] trig_q;
  logic [NCH-1:0]   clash, pulse, src_hit;

  wire [SW-1:0]    w_src  = cfg_wdata[SW-1:0];
  wire [NTRIG-1:0] t_rise = trig_in & ~trig_q;
  wire             wr_ok  = cfg_we && (w_src == '0 || clash == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) trig_q <= '0;
    else        trig_q <= trig_in;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign clash[c] = (AW'(c) != cfg_addr) && (src_r[c] == w_src);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        en_r[c]  <= 1'b0;
        tm_r[c]  <= 1'b0;
        ao_r[c]  <= 1'b0;
        src_r[c] <= '0;
      end else if (wr_ok && cfg_addr == AW'(c)) begin
        en_r[c]  <= cfg_wdata[31];
        tm_r[c]  <= cfg_wdata[30] && (c < NTRIG);
        ao_r[c]  <= cfg_wdata[29];
        src_r[c] <= w_src;
      end

    if (c < NTRIG) begin : g_trig
      assign pulse[c] = t_rise[c];
    end else begin : g_notrig
      assign pulse[c] = 1'b0;
    end

    assign src_hit[c] = (src_r[c] != '0) && periph_req[src_r[c]];
    assign ch_req[c]  = en_r[c] & (ao_r[c] | (src_hit[c] & (~tm_r[c] | pulse[c])));
  end

  assign cfg_rdata = {en_r[cfg_addr], tm_r[cfg_addr], ao_r[cfg_addr], PADW'(0), src_r[cfg_addr]};
endmodule

module dma_req_router_chk #(
  parameter int NCH   = 32,
  parameter int NSRC  = 256,
  parameter int NTRIG = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cfg_we,
  input logic [$clog2(NCH)-1:0]  cfg_addr,
  input logic [31:0]             cfg_wdata,
  input logic [31:0]             cfg_rdata,
  input logic [NTRIG-1:0]        trig_in,
  input logic [NCH-1:0]          ch_req,
  input logic [NCH-1:0]          en_r,
  input logic [NCH-1:0]          tm_r,
  input logic [NCH-1:0]          ao_r,
  input logic [$clog2(NSRC)-1:0] src_r [NCH]
);
  localparam int AW = $clog2(NCH);
  localparam int SW = $clog2(NSRC);

  logic dup, taken;

  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < NCH; i++)
      for (int j = i + 1; j < NCH; j++)
        if (src_r[i] != '0 && src_r[i] == src_r[j]) dup = 1'b1;
  end

  always_comb begin
    taken = 1'b0;
    for (int j = 0; j < NCH; j++)
      if (AW'(j) != cfg_addr && cfg_wdata[SW-1:0] != '0 && src_r[j] == cfg_wdata[SW-1:0]) taken = 1'b1;
  end

  // R7
  unique_src_chk: assert property (@(posedge clk) disable iff (!rst_n) !dup);

  // R2
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) cfg_rdata[28:8] == '0);

  // R10
  hi_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr >= AW'(NTRIG)) |-> !cfg_rdata[30]);

  for (genvar c = 0; c < NCH; c++) begin : g_a
    // R3
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !en_r[c] |-> !ch_req[c]);

    // R6
    forced_on_chk: assert property (@(posedge clk) disable iff (!rst_n) (en_r[c] && ao_r[c]) |-> ch_req[c]);

    // R7
    drop_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == AW'(c) && taken) |=> $stable({en_r[c], tm_r[c], ao_r[c], src_r[c]}));

    if (c < NTRIG) begin : g_t
      // R9
      no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_r[c] && tm_r[c] && !ao_r[c] && !trig_in[c]) |-> !ch_req[c]);
    end
  end
endmodule

bind dma_req_router dma_req_router_chk #(.NCH(NCH), .NSRC(NSRC), .NTRIG(NTRIG)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .trig_in(trig_in), .ch_req(ch_req),
  .en_r(en_r), .tm_r(tm_r), .ao_r(ao_r), .src_r(src_r)
);

// File: tb/dma_req_router_tb.sv
module dma_req_router_tb_top;
  localparam int NCH = 32, NSRC = 256, NTRIG = 4;

  logic             clk = 0, rst_n = 0, cfg_we = 0;
  logic [4:0]       cfg_addr = '0;
  logic [31:0]      cfg_wdata = '0, cfg_rdata;
  logic [NSRC-1:0]  periph_req = '0;
  logic [NTRIG-1:0] trig_in = '0;
  logic [NCH-1:0]   ch_req;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  dma_req_router #(.NCH(NCH), .NSRC(NSRC), .NTRIG(NTRIG)) dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 5'(ch); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd(input int ch, output logic [31:0] v);
    cfg_addr = 5'(ch);
    #1 v = cfg_rdata;
  endtask

  task automatic clear_all();
    for (int c = 0; c < NCH; c++) wr(c, 32'h0);
    periph_req = '0; trig_in = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    int nz = 0;
    for (int c = 0; c < NCH; c++) begin rd(c, v); if (v != 0) nz++; end
    chk("R1 words", 32'(nz), 0);
    chk("R1 req", ch_req, 0);
  endtask

  task automatic t_layout();
    logic [31:0] v;
    wr(2, 32'hFFFF_FF05); rd(2, v); chk("R2 all-set", v, 32'hE000_0005);
    wr(2, 32'h2000_0000); rd(2, v); chk("R2 forced-only", v, 32'h2000_0000);
    clear_all();
  endtask

  task automatic t_disabled();
    wr(1, 32'h2000_0007); periph_req[7] = 1; #1;
    chk("R3 disabled", 32'(ch_req[1]), 0);
    clear_all();
  endtask

  task automatic t_normal();
    wr(1, 32'h8000_0007); wr(3, 32'h8000_00FF);
    periph_req[7] = 1; #1;
    chk("R4 on", 32'(ch_req), 32'h2);
    periph_req[255] = 1; periph_req[7] = 0; #1;
    chk("R4 other", 32'(ch_req), 32'h8);
    periph_req = '0; #1;
    chk("R4 off", 32'(ch_req), 0);
    clear_all();
  endtask

  task automatic t_nosrc();
    wr(9, 32'h8000_0000); periph_req = '1; #1;
    chk("R5 src0", 32'(ch_req[9]), 0);
    clear_all();
  endtask

  task automatic t_forced();
    wr(10, 32'hA000_0000); #1;
    chk("R6 forced", 32'(ch_req[10]), 1);
    wr(10, 32'hA000_0011); periph_req[17] = 0; #1;
    chk("R6 src low", 32'(ch_req[10]), 1);
    clear_all();
  endtask

  task automatic t_excl();
    logic [31:0] v;
    wr(5, 32'h8000_0014); wr(6, 32'h8000_0003);
    wr(6, 32'hA000_0014); rd(6, v);
    chk("R7 readback", v, 32'h8000_0003);
    periph_req[20] = 1; #1;
    chk("R7 req", 32'(ch_req[6]), 0);
    chk("R7 owner", 32'(ch_req[5]), 1);
    clear_all();
  endtask

  task automatic t_release();
    logic [31:0] v;
    wr(5, 32'h8000_0014);
    wr(5, 32'hA000_0014); rd(5, v); chk("R8 same", v, 32'hA000_0014);
    wr(5, 32'h8000_0015);
    wr(6, 32'h8000_0014); rd(6, v); chk("R8 freed", v, 32'h8000_0014);
    clear_all();
  endtask

  task automatic t_trig();
    wr(0, 32'hC000_001E);
    @(negedge clk); periph_req[30] = 1; #1;
    chk("R9 no pulse", 32'(ch_req[0]), 0);
    @(negedge clk); trig_in[0] = 1; #1;
    chk("R9 rise", 32'(ch_req[0]), 1);
    @(negedge clk); #1;
    chk("R9 held", 32'(ch_req[0]), 0);
    @(negedge clk); trig_in[0] = 0; periph_req[30] = 0;
    @(negedge clk); trig_in[0] = 1; #1;
    chk("R9 src low", 32'(ch_req[0]), 0);
    clear_all();
  endtask

  task automatic t_hitrig();
    logic [31:0] v;
    wr(12, 32'hC000_0040); rd(12, v);
    chk("R10 readback", v, 32'h8000_0040);
    periph_req[64] = 1; #1;
    chk("R10 level", 32'(ch_req[12]), 1);
    @(negedge clk); #1;
    chk("R10 held", 32'(ch_req[12]), 1);
    clear_all();
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #35 rst_n = 1;
    t_reset();
    t_layout();
    t_disabled();
    t_normal();
    t_nosrc();
    t_forced();
    t_excl();
    t_release();
    t_trig();
    t_hitrig();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule